// File: doc/BRIEF.md
# Memory-Mapped Signed Division Unit

This block is a signed integer divider that sits on a 32-bit register bus. Software loads a divisor, then starts a division by writing the dividend. Two operations exist. Writing the single-word dividend register starts a 32-by-32 divide. Writing the low word of a two-word dividend starts a 64-by-32 divide, and the high word is taken from the remainder register.

Division rounds toward zero, and the remainder carries the sign of the dividend. The unit produces one quotient bit per clock with a shift-and-subtract loop on magnitudes. A busy flag is visible both on a port and at a status offset. Results are written to a primary quotient/remainder pair and also to a read-only mirror pair. A zero divisor clears the result registers, and a 64-by-32 quotient too large for 32 bits saturates.

Top module: `sdiv_unit`

## Requirements
- R1: After reset every readable offset (0x00, 0x04, 0x10, 0x14, 0x18, 0x1C, 0x20) reads zero and `busy` is low.
- R2: A write to offset 0x04 while idle starts a signed 32/32 divide of the written value by the register at 0x00. The quotient lands at 0x04, 0x14 and 0x1C, and the remainder lands at 0x10 and 0x18.
- R3: A write to offset 0x14 while idle starts a signed 64/32 divide whose dividend is {register 0x10, written value}. The remainder lands at 0x10 and 0x18, the quotient lands at 0x14 and 0x1C, and 0x04 keeps its old value.
- R4: Quotients round toward zero, and a nonzero remainder has the sign of the dividend.
- R5: A 64/32 quotient outside the signed 32-bit range reads 0x7FFFFFFF when the true quotient is positive and 0x80000000 when it is negative.
- R6: With a zero divisor, offsets 0x10, 0x14, 0x18 and 0x1C become zero. For a 32/32 start, 0x04 keeps the written dividend.
- R7: Offset 0x20 bit 0 and the `busy` port go high on the cycle after a start. They stay high for 33 cycles for a 32/32 divide, 65 cycles for a 64/32 divide, and 1 cycle for a zero divisor.
- R8: While busy, every bus write is ignored, whether it targets an operand or a result register.
- R9: Offsets 0x18 and 0x1C are read-only. Writes to 0x00 or 0x10 never start a divide.
- R10: A 32/32 divide of 0x80000000 by 0xFFFFFFFF yields quotient 0x80000000 (the low 32 bits) and remainder 0, with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for one cycle |
| busAddr | input | 6 | Write byte offset |
| busWdata | input | 32 | Write data |
| rdAddr | input | 6 | Read byte offset |
| rdData | output | 32 | Combinational read data at `rdAddr` |
| busy | output | 1 | High while a divide is in progress |

## Verification
The 32/32 path is driven with all four sign combinations of the same operand pair. These tell apart truncating from flooring division and show whether the remainder sign follows the dividend or the divisor. The 64/32 path is driven with a high word that is zero, one that is all ones (a negative value), and high words large enough to overflow in both directions, which separates correct dividend concatenation from saturation. Zero divisors in both modes, the most negative value divided by minus one, writes during a divide, and writes to the mirror and operand offsets probe the boundaries.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int OFF_DIVISOR = 'h00;
  localparam int OFF_DVD32   = 'h04;
  localparam int OFF_REM     = 'h10;
  localparam int OFF_QUO     = 'h14;
  localparam int OFF_REM_M   = 'h18;
  localparam int OFF_QUO_M   = 'h1C;
  localparam int OFF_STATUS  = 'h20;

  typedef struct packed {
    logic load;    // capture operands, start iterating
    logic step;    // one quotient bit
    logic finish;  // sign-fix and write back
  } divCtrl_t;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl import sdiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     startIs64,
  input  logic     divZero,
  output divCtrl_t ctrl,
  output logic     busy
);
  localparam int CNT_W = $clog2(2 * W + 1);
  localparam logic [CNT_W-1:0] LAST32 = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] LAST64 = CNT_W'(2 * W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;
  state_t state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state   <= divZero ? ST_FIN : ST_RUN;
          stepCnt <= startIs64 ? LAST64 : LAST32;
        end
        ST_RUN: begin
          if (stepCnt == '0) state <= ST_FIN;
          else stepCnt <= stepCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && startReq;
    ctrl.step   = (state == ST_RUN);
    ctrl.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sdiv_dp.sv
module sdiv_dp import sdiv_pkg::*; #(
  parameter int W      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [W-1:0]      busWdata,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              busy,
  input  divCtrl_t          ctrl,
  output logic [W-1:0]      rdData,
  output logic              startReq,
  output logic              startIs64,
  output logic              divZero,
  output logic [W-1:0]      divisorR,
  output logic [W-1:0]      remR,
  output logic [W-1:0]      quoR,
  output logic [W-1:0]      remM,
  output logic [W-1:0]      quoM
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] SAT_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  dvdLoR;
  logic [W-1:0]  acc;
  logic [DW-1:0] qsh;
  logic [W-1:0]  dsrMag;
  logic          qNeg, rNeg, is64, zeroHeld;

  logic wrOk;
  assign wrOk      = busWr && !busy;
  assign startIs64 = (busAddr == ADDR_W'(OFF_QUO));
  assign startReq  = wrOk && (startIs64 || busAddr == ADDR_W'(OFF_DVD32));
  assign divZero   = (divisorR == '0);

  // operand preparation at load
  logic [DW-1:0] dvdFull, dvdMag;
  logic          dvdNeg;
  assign dvdFull = startIs64 ? {remR, busWdata} : {{W{busWdata[W-1]}}, busWdata};
  assign dvdNeg  = dvdFull[DW-1];
  assign dvdMag  = dvdNeg ? -dvdFull : dvdFull;

  // one shift-subtract step
  logic [W:0]   accShift;
  logic [W+1:0] diff;
  logic         qBit;
  assign accShift = {acc, qsh[DW-1]};
  assign diff     = {1'b0, accShift} - {2'b00, dsrMag};
  assign qBit     = !diff[W+1];

  // sign fix-up and saturation at finish
  logic [DW-1:0] qSigned;
  logic [W-1:0]  remSigned, quoFinal;
  logic          ovf;
  assign qSigned   = qNeg ? -qsh : qsh;
  assign remSigned = rNeg ? -acc : acc;
  assign ovf       = is64 && !(&qSigned[DW-1:W-1] || !(|qSigned[DW-1:W-1]));
  assign quoFinal  = ovf ? (qNeg ? SAT_NEG : SAT_POS) : qSigned[W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisorR <= '0; dvdLoR <= '0; remR <= '0; quoR <= '0;
      remM <= '0; quoM <= '0; acc <= '0; qsh <= '0; dsrMag <= '0;
      qNeg <= 1'b0; rNeg <= 1'b0; is64 <= 1'b0; zeroHeld <= 1'b0;
    end else begin
      if (wrOk) begin
        if (busAddr == ADDR_W'(OFF_DIVISOR)) divisorR <= busWdata;
        if (busAddr == ADDR_W'(OFF_DVD32))   dvdLoR   <= busWdata;
        if (busAddr == ADDR_W'(OFF_REM))     remR     <= busWdata;
        if (busAddr == ADDR_W'(OFF_QUO))     quoR     <= busWdata;
      end
      if (ctrl.load) begin
        is64     <= startIs64;
        zeroHeld <= divZero;
        acc      <= '0;
        qsh      <= startIs64 ? dvdMag : {dvdMag[W-1:0], {W{1'b0}}};
        dsrMag   <= divisorR[W-1] ? -divisorR : divisorR;
        qNeg     <= dvdNeg ^ divisorR[W-1];
        rNeg     <= dvdNeg;
      end
      if (ctrl.step) begin
        acc <= qBit ? diff[W-1:0] : accShift[W-1:0];
        qsh <= {qsh[DW-2:0], qBit};
      end
      if (ctrl.finish) begin
        if (zeroHeld) begin
          remR <= '0; remM <= '0; quoR <= '0; quoM <= '0;
        end else begin
          remR <= remSigned; remM <= remSigned;
          quoR <= quoFinal;  quoM <= quoFinal;
          if (!is64) dvdLoR <= quoFinal;
        end
      end
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_W'(OFF_DIVISOR): rdData = divisorR;
      ADDR_W'(OFF_DVD32):   rdData = dvdLoR;
      ADDR_W'(OFF_REM):     rdData = remR;
      ADDR_W'(OFF_QUO):     rdData = quoR;
      ADDR_W'(OFF_REM_M):   rdData = remM;
      ADDR_W'(OFF_QUO_M):   rdData = quoM;
      ADDR_W'(OFF_STATUS):  rdData = {{(W-1){1'b0}}, busy};
      default:              rdData = '0;
    endcase
  end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit import sdiv_pkg::*; #(
  parameter int W      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [W-1:0]      busWdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [W-1:0]      rdData,
  output logic              busy
);
  divCtrl_t ctrl;
  logic startReq, startIs64, divZero, finishStb;
  logic [W-1:0] divisorR, remR, quoR, remM, quoM;

  assign finishStb = ctrl.finish;

  sdiv_ctrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startIs64(startIs64),
    .divZero(divZero), .ctrl(ctrl), .busy(busy)
  );

  sdiv_dp #(.W(W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .rdAddr(rdAddr), .busy(busy), .ctrl(ctrl),
    .rdData(rdData), .startReq(startReq), .startIs64(startIs64),
    .divZero(divZero), .divisorR(divisorR), .remR(remR), .quoR(quoR),
    .remM(remM), .quoM(quoM)
  );
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int W      = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              finishStb,
  input logic [W-1:0]      divisorR,
  input logic [W-1:0]      remR,
  input logic [W-1:0]      quoR,
  input logic [W-1:0]      remM,
  input logic [W-1:0]      quoM
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busWr && (busAddr == ADDR_W'('h04) || busAddr == ADDR_W'('h14))) |=> busy); // R7

  AST_MIRROR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (remR == remM && quoR == quoM)); // R2

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !finishStb) |=> ($stable(remR) && $stable(quoR) && $stable(divisorR))); // R8

  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && divisorR == '0) |-> (remR == '0 && quoR == '0 && remM == '0 && quoM == '0)); // R6

  AST_NO_FALSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busWr && (busAddr == ADDR_W'('h00) || busAddr == ADDR_W'('h10))) |=> !busy); // R9
endmodule

bind sdiv_unit sdiv_chk #(.W(W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .busWr(busWr), .busAddr(busAddr),
  .finishStb(finishStb), .divisorR(divisorR), .remR(remR), .quoR(quoR),
  .remM(remM), .quoM(quoM)
);

// File: tb/tb_sdiv_unit.sv
module tb_sdiv_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [5:0] rdAddr = '0;
  logic [31:0] rdData;
  logic busy;

  always #10 clk = ~clk;

  sdiv_unit dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  typedef struct {
    logic [5:0]  addr;
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t sb[$];

  int checks = 0;
  int fails = 0;
  logic [31:0] exp04 = '0;
  logic prevBusy = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic push(input logic [5:0] a, input logic [31:0] v, input string tag);
    item_t it;
    it.addr = a; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: on each falling busy, compare all pending expectations
  initial begin
    forever begin
      @(negedge clk);
      if (prevBusy && !busy) begin
        while (sb.size() != 0) begin
          item_t it;
          logic [31:0] v;
          it = sb.pop_front();
          rd(it.addr, v);
          check(it.tag, v, it.val);
        end
      end
      prevBusy = busy;
    end
  end

  // driver: program operands, push expectations, start, time busy
  task automatic runDiv(input bit is64, input logic [31:0] dvs, input logic [31:0] hi,
                        input logic [31:0] lo, input string tag);
    logic signed [95:0] dd, bb, qq, rr;
    logic [31:0] q, r;
    int cnt, expBusy;
    wr(6'h00, dvs);
    if (is64) wr(6'h10, hi);
    dd = is64 ? {{32{hi[31]}}, hi, lo} : {{64{lo[31]}}, lo};
    bb = {{64{dvs[31]}}, dvs};
    if (dvs == 32'h0) begin
      q = '0; r = '0;
      if (!is64) exp04 = lo;
      expBusy = 1;
    end else begin
      qq = dd / bb;
      rr = dd % bb;
      if (is64 && (qq > 96'sh7fffffff || qq < -96'sh80000000))
        q = (qq < 0) ? 32'h80000000 : 32'h7fffffff;
      else
        q = qq[31:0];
      r = rr[31:0];
      if (!is64) exp04 = q;
      expBusy = is64 ? 65 : 33;
    end
    push(6'h10, r, tag);
    push(6'h14, q, tag);
    push(6'h18, r, tag);
    push(6'h1C, q, tag);
    push(6'h04, exp04, tag);
    wr(is64 ? 6'h14 : 6'h04, lo);
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    check({"R7 busy length ", tag}, cnt, expBusy);
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a <= 'h20; a += 4) begin
      if (a == 'h00 || a == 'h04 || a >= 'h10) begin
        rd(6'(a), v);
        check("R1 reset register", v, 32'h0);
      end
    end
    check("R1 reset busy", {31'b0, busy}, 32'h0);

    // R2 / R4 sign combinations
    runDiv(1'b0, 32'd7, 32'h0, 32'd100, "R2 100/7");
    runDiv(1'b0, 32'd7, 32'h0, -32'sd100, "R4 -100/7");
    runDiv(1'b0, -32'sd7, 32'h0, 32'd100, "R4 100/-7");
    runDiv(1'b0, -32'sd7, 32'h0, -32'sd100, "R4 -100/-7");
    runDiv(1'b0, 32'd9, 32'h0, 32'd3, "R2 small dividend");
    // R10 most negative by minus one
    runDiv(1'b0, 32'hffffffff, 32'h0, 32'h80000000, "R10 min/-1");
    // R6 zero divisor, 32-bit start
    runDiv(1'b0, 32'h0, 32'h0, 32'd1234, "R6 zero32");

    // R3 64/32 cases
    runDiv(1'b1, 32'd3, 32'h0, 32'd1000, "R3 pos64");
    runDiv(1'b1, 32'd7, 32'hffffffff, -32'sd1000, "R3 neg64");
    runDiv(1'b1, 32'd3, 32'h1, 32'h0, "R3 wide fit");
    // R5 saturation
    runDiv(1'b1, 32'd1, 32'h1, 32'h0, "R5 sat pos");
    runDiv(1'b1, 32'hffffffff, 32'h1, 32'h0, "R5 sat neg");
    runDiv(1'b1, 32'd1, 32'h80000000, 32'h0, "R5 sat most neg");
    runDiv(1'b1, -32'sd5, 32'hffffffff, 32'hfffffff0, "R4 neg/neg64");
    // R6 zero divisor, 64-bit start
    runDiv(1'b1, 32'h0, 32'h5, 32'h9, "R6 zero64");

    // R8 writes ignored while busy
    wr(6'h00, 32'd7);
    wr(6'h04, 32'd100);
    rd(6'h20, v);
    check("R7 status busy bit", v, 32'h1);
    wr(6'h10, 32'hdeadbeef);
    wr(6'h00, 32'h0);
    wr(6'h14, 32'h12345678);
    while (busy) @(negedge clk);
    @(negedge clk);
    rd(6'h10, v); check("R8 remainder kept", v, 32'd2);
    rd(6'h00, v); check("R8 divisor kept", v, 32'd7);
    rd(6'h14, v); check("R8 quotient kept", v, 32'd14);
    rd(6'h04, v); check("R8 dividend result", v, 32'd14);

    // R9 read-only mirrors and non-start offsets
    wr(6'h18, 32'h55);
    rd(6'h18, v); check("R9 mirror rem read-only", v, 32'd2);
    wr(6'h1C, 32'h66);
    rd(6'h1C, v); check("R9 mirror quo read-only", v, 32'd14);
    wr(6'h00, 32'd5);
    check("R9 divisor write no start", {31'b0, busy}, 32'h0);
    wr(6'h10, 32'd3);
    check("R9 high write no start", {31'b0, busy}, 32'h0);
    rd(6'h20, v); check("R9 status idle", v, 32'h0);
    rd(6'h10, v); check("R9 high word stored", v, 32'd3);

    finishRun();
  end
endmodule